// File: doc/BRIEF.md
# Ordered Store Queue with Load Disambiguation

This block holds every store that has been dispatched but has not yet reached memory, in program order. A store is given an entry when it is dispatched. Its address and its data are written into that entry later, each on its own port and addressed by entry slot, as soon as the producing unit has them. The commit stage releases stores one at a time, oldest first. Released stores are written to memory strictly in order, and an entry is freed only when the memory port accepts its write.

A load records the queue's tail position when it issues, which marks exactly which stores come before it. When the load's address is ready, the block looks at the live stores older than that position and makes one decision. The load stalls if any of those stores still has no address. Otherwise the load takes the data of the youngest matching older store, or the reorder-buffer tag of that store's data producer if the data is not yet known. If no older store matches, the load goes to memory.

A flush trims the tail back to a given position. This drops the uncommitted stores younger than that point and leaves committed stores draining.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `allocReady` is 1, `memWrValid` is 0 and `tailPos` is 0.
- R2: Slots are handed out in order. `allocSlot` is the tail position modulo DEPTH (a power of two, at least 2). `tailPos` is a wrapping counter modulo 2*DEPTH that advances by one for each accepted store. `allocReady` is 0 while DEPTH stores are live or a flush is requested, and an allocation offered then is dropped.
- R3: The address and the data of an entry are filled independently, in any order, by slot index. A new allocation clears both known flags of its slot.
- R4: A load whose older stores include one with an unknown address gets `ldKind` = 1 (stall). This takes priority over any match.
- R5: If the youngest older store whose address equals `ldAddr` has known data, the load gets `ldKind` = 2 and that data on `ldData`.
- R6: If that youngest matching older store has no data yet, the load gets `ldKind` = 3 and the store's producer tag on `ldTag`.
- R7: With all older addresses known and none equal to `ldAddr`, the load gets `ldKind` = 4 (memory). With `ldValid` low, `ldKind` is 0.
- R8: Stores at or after the load's recorded position `ldPos` have no effect on the load's decision.
- R9: `commitValid` releases the oldest unreleased store. `memWrValid` is raised only for the oldest live store, once it is released and both its address and its data are known, and it carries that store's address and data.
- R10: The oldest store stays on the memory port, unchanged, until `memWrReady` is seen; only then is its entry freed.
- R11: `flushValid` sets the tail to `flushPos` (between the release point and the tail). Younger uncommitted stores are removed; released stores keep draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Dispatch a store |
| allocTag | input | TAG_W | Reorder-buffer tag of the store's data producer |
| allocReady | output | 1 | Queue can accept a store this cycle |
| allocSlot | output | IDX_W | Slot the next store receives |
| tailPos | output | PTR_W | Tail position for loads to record at issue |
| addrValid | input | 1 | Write an address into a slot |
| addrSlot | input | IDX_W | Slot for the address |
| addrValue | input | ADDR_W | Store address |
| dataValid | input | 1 | Write data into a slot |
| dataSlot | input | IDX_W | Slot for the data |
| dataValue | input | DATA_W | Store data |
| ldValid | input | 1 | Load lookup request |
| ldAddr | input | ADDR_W | Load address |
| ldPos | input | PTR_W | Tail position recorded at load issue |
| ldKind | output | 3 | 0 idle, 1 stall, 2 forward, 3 wait on tag, 4 memory |
| ldData | output | DATA_W | Forwarded data |
| ldTag | output | TAG_W | Producer tag to wait on |
| commitValid | input | 1 | Release the oldest unreleased store |
| flushValid | input | 1 | Trim the tail |
| flushPos | input | PTR_W | New tail position |
| memWrValid | output | 1 | Memory write request |
| memWrReady | input | 1 | Memory accepts the write |
| memWrAddr | output | ADDR_W | Write address |
| memWrData | output | DATA_W | Write data |

## Verification
The bench builds the queue with DEPTH = 4, 8-bit addresses, 16-bit data and 4-bit tags. The shallow queue makes the full condition, the dropped allocation and the wrap of both slot and position counters happen within a few dozen cycles. The 8-bit address space lets the random phase draw addresses from a pool of four values, so several older stores often match the same load and the youngest-wins choice is exercised. The directed phase walks a single load through stall, tag, forward and memory outcomes, holds back-pressure on the memory port, and flushes while released stores are still draining.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [2:0] {
    LD_IDLE    = 3'd0,
    LD_STALL   = 3'd1,
    LD_FORWARD = 3'd2,
    LD_WAITTAG = 3'd3,
    LD_MEMORY  = 3'd4
  } ldKind_e;

  // Write strobes from control to the entry storage.
  typedef struct packed {
    logic alloc;
    logic addrFill;
    logic dataFill;
  } sqStrobe_t;

endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocValid,
  output logic             allocReady,
  input  logic             addrValid,
  input  logic             dataValid,
  input  logic             commitValid,
  input  logic             flushValid,
  input  logic [PTR_W-1:0] flushPos,
  input  logic             headKnown,
  input  logic             memWrReady,
  output logic             memWrValid,
  output sqStrobe_t        strobe,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic [PTR_W-1:0] liveCount
);

  localparam logic [PTR_W-1:0] FULL_COUNT = PTR_W'(DEPTH);

  logic [PTR_W-1:0] commitPtr;
  logic             isFull;
  logic             hasReleased;
  logic             popEn;

  assign liveCount   = tailPtr - headPtr;
  assign isFull      = (liveCount == FULL_COUNT);
  assign allocReady  = !isFull && !flushValid;
  assign hasReleased = (headPtr != commitPtr);
  assign memWrValid  = hasReleased && headKnown;
  assign popEn       = memWrValid && memWrReady;

  always_comb begin
    strobe          = '0;
    strobe.alloc    = allocValid && allocReady;
    strobe.addrFill = addrValid;
    strobe.dataFill = dataValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr   <= '0;
      commitPtr <= '0;
      tailPtr   <= '0;
    end else begin
      if (popEn)       headPtr   <= headPtr + 1'b1;
      if (commitValid) commitPtr <= commitPtr + 1'b1;
      if (flushValid)        tailPtr <= flushPos;
      else if (strobe.alloc) tailPtr <= tailPtr + 1'b1;
    end
  end

  // Live stores never exceed the number of slots.
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    liveCount <= FULL_COUNT);

  // A release must name a store that exists.
  assert_commit_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commitValid |-> (commitPtr != tailPtr));

  // The new tail lies between the release point and the current tail.
  assert_flush_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flushValid |-> ((flushPos - commitPtr) <= (tailPtr - commitPtr)));

  // Released stores are never trimmed away by a flush.
  assert_release_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flushValid && !commitValid) |=> ((tailPtr - headPtr) >= (commitPtr - headPtr)));

endmodule

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sqStrobe_t         strobe,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic [IDX_W-1:0]  addrSlot,
  input  logic [ADDR_W-1:0] addrValue,
  input  logic [IDX_W-1:0]  dataSlot,
  input  logic [DATA_W-1:0] dataValue,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic [PTR_W-1:0]  liveCount,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [PTR_W-1:0]  ldPos,
  output ldKind_e           ldKind,
  output logic [DATA_W-1:0] ldData,
  output logic [TAG_W-1:0]  ldTag,
  output logic              headKnown,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  logic [ADDR_W-1:0] entAddr   [DEPTH];
  logic [DATA_W-1:0] entData   [DEPTH];
  logic [TAG_W-1:0]  entTag    [DEPTH];
  logic              addrKnown [DEPTH];
  logic              dataKnown [DEPTH];

  logic [IDX_W-1:0]  allocSlot;
  logic [IDX_W-1:0]  headSlot;

  assign allocSlot = tailPtr[IDX_W-1:0];
  assign headSlot  = headPtr[IDX_W-1:0];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addrKnown[s] <= 1'b0;
        dataKnown[s] <= 1'b0;
      end else begin
        if (strobe.alloc && allocSlot == IDX_W'(s)) begin
          addrKnown[s] <= 1'b0;
          dataKnown[s] <= 1'b0;
        end
        if (strobe.addrFill && addrSlot == IDX_W'(s)) addrKnown[s] <= 1'b1;
        if (strobe.dataFill && dataSlot == IDX_W'(s)) dataKnown[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.alloc && allocSlot == IDX_W'(s))   entTag[s]  <= allocTag;
      if (strobe.addrFill && addrSlot == IDX_W'(s)) entAddr[s] <= addrValue;
      if (strobe.dataFill && dataSlot == IDX_W'(s)) entData[s] <= dataValue;
    end
  end

  assign headKnown = addrKnown[headSlot] && dataKnown[headSlot];
  assign memWrAddr = entAddr[headSlot];
  assign memWrData = entData[headSlot];

  // Age-ordered scan of the stores older than the load.
  logic [PTR_W-1:0] olderDiff;
  logic [PTR_W-1:0] olderCnt;
  logic             anyUnknown;
  logic             matchHit;
  logic [IDX_W-1:0] matchSlot;

  assign olderDiff = ldPos - headPtr;
  assign olderCnt  = (olderDiff <= liveCount) ? olderDiff : '0;

  always_comb begin
    logic [PTR_W-1:0] scanPos;
    logic [IDX_W-1:0] scanSlot;
    anyUnknown = 1'b0;
    matchHit   = 1'b0;
    matchSlot  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scanPos  = headPtr + PTR_W'(k);
      scanSlot = scanPos[IDX_W-1:0];
      if (PTR_W'(k) < olderCnt) begin
        if (!addrKnown[scanSlot]) begin
          anyUnknown = 1'b1;
        end else if (entAddr[scanSlot] == ldAddr) begin
          matchHit  = 1'b1;   // later iterations are younger
          matchSlot = scanSlot;
        end
      end
    end
  end

  always_comb begin
    ldKind = LD_IDLE;
    ldData = '0;
    ldTag  = '0;
    if (ldValid) begin
      if (anyUnknown) begin
        ldKind = LD_STALL;
      end else if (matchHit && dataKnown[matchSlot]) begin
        ldKind = LD_FORWARD;
        ldData = entData[matchSlot];
      end else if (matchHit) begin
        ldKind = LD_WAITTAG;
        ldTag  = entTag[matchSlot];
      end else begin
        ldKind = LD_MEMORY;
      end
    end
  end

  // Fills target live entries only.
  logic [IDX_W-1:0] addrOff;
  logic [IDX_W-1:0] dataOff;
  assign addrOff = addrSlot - headSlot;
  assign dataOff = dataSlot - headSlot;

  assert_addr_fill_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.addrFill |-> ({1'b0, addrOff} < liveCount));

  assert_data_fill_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.dataFill |-> ({1'b0, dataOff} < liveCount));

  // A filled address is seen as known on the next cycle unless reallocated.
  assert_addr_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.addrFill && !(strobe.alloc && allocSlot == addrSlot))
      |=> addrKnown[$past(addrSlot)]);

endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocValid,
  input  logic [TAG_W-1:0]  allocTag,
  output logic              allocReady,
  output logic [IDX_W-1:0]  allocSlot,
  output logic [PTR_W-1:0]  tailPos,
  input  logic              addrValid,
  input  logic [IDX_W-1:0]  addrSlot,
  input  logic [ADDR_W-1:0] addrValue,
  input  logic              dataValid,
  input  logic [IDX_W-1:0]  dataSlot,
  input  logic [DATA_W-1:0] dataValue,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [PTR_W-1:0]  ldPos,
  output logic [2:0]        ldKind,
  output logic [DATA_W-1:0] ldData,
  output logic [TAG_W-1:0]  ldTag,
  input  logic              commitValid,
  input  logic              flushValid,
  input  logic [PTR_W-1:0]  flushPos,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  sqStrobe_t        strobe;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [PTR_W-1:0] liveCount;
  logic             headKnown;
  ldKind_e          ldKindE;

  sq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .allocValid (allocValid),
    .allocReady (allocReady),
    .addrValid  (addrValid),
    .dataValid  (dataValid),
    .commitValid(commitValid),
    .flushValid (flushValid),
    .flushPos   (flushPos),
    .headKnown  (headKnown),
    .memWrReady (memWrReady),
    .memWrValid (memWrValid),
    .strobe     (strobe),
    .headPtr    (headPtr),
    .tailPtr    (tailPtr),
    .liveCount  (liveCount)
  );

  sq_data #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .TAG_W (TAG_W)
  ) data_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .allocTag (allocTag),
    .addrSlot (addrSlot),
    .addrValue(addrValue),
    .dataSlot (dataSlot),
    .dataValue(dataValue),
    .headPtr  (headPtr),
    .tailPtr  (tailPtr),
    .liveCount(liveCount),
    .ldValid  (ldValid),
    .ldAddr   (ldAddr),
    .ldPos    (ldPos),
    .ldKind   (ldKindE),
    .ldData   (ldData),
    .ldTag    (ldTag),
    .headKnown(headKnown),
    .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  assign ldKind    = ldKindE;
  assign allocSlot = tailPtr[IDX_W-1:0];
  assign tailPos   = tailPtr;

  // A write held back by the memory port stays put.
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrValid && !memWrReady) |=> (memWrValid && $stable(memWrAddr) && $stable(memWrData)));

  // Forwarded data only appears on a forward decision.
  assert_fwd_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ldKindE != LD_FORWARD) |-> (ldData == '0));

endmodule

// File: tb/store_queue_tb_top.sv
`timescale 1ns/1ps
module store_queue_tb_top;

  localparam int DEPTH  = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 4;
  localparam int IDX_W  = 2;
  localparam int PTR_W  = 3;
  localparam int PMOD   = 2 * DEPTH;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              allocValid = 1'b0;
  logic [TAG_W-1:0]  allocTag = '0;
  logic              allocReady;
  logic [IDX_W-1:0]  allocSlot;
  logic [PTR_W-1:0]  tailPos;
  logic              addrValid = 1'b0;
  logic [IDX_W-1:0]  addrSlot = '0;
  logic [ADDR_W-1:0] addrValue = '0;
  logic              dataValid = 1'b0;
  logic [IDX_W-1:0]  dataSlot = '0;
  logic [DATA_W-1:0] dataValue = '0;
  logic              ldValid = 1'b0;
  logic [ADDR_W-1:0] ldAddr = '0;
  logic [PTR_W-1:0]  ldPos = '0;
  logic [2:0]        ldKind;
  logic [DATA_W-1:0] ldData;
  logic [TAG_W-1:0]  ldTag;
  logic              commitValid = 1'b0;
  logic              flushValid = 1'b0;
  logic [PTR_W-1:0]  flushPos = '0;
  logic              memWrValid;
  logic              memWrReady = 1'b1;
  logic [ADDR_W-1:0] memWrAddr;
  logic [DATA_W-1:0] memWrData;

  always #2.5 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (.*);

  // Behavioural reference: unbounded positions and per-slot records.
  int mHead = 0, mCommit = 0, mTail = 0;
  int mAddr [DEPTH];
  int mData [DEPTH];
  int mTagV [DEPTH];
  bit mAK   [DEPTH];
  bit mDK   [DEPTH];
  int ldPosInt = 0;
  int flushPosInt = 0;

  int checks = 0, fails = 0;
  bit finished = 0;
  string memReq = "R9";
  string ldReq  = "";

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare outputs against the model, advance the model, cross the edge.
  task automatic cyc();
    bit eReady, eWr, stall, hit;
    int hs, hi, eKind;
    string req;
    #1;
    eReady = (mTail - mHead < DEPTH) && !flushValid;
    chk("R2", "allocReady", allocReady, eReady);
    chk("R2", "tailPos", tailPos, mTail % PMOD);
    chk("R2", "allocSlot", allocSlot, mTail % DEPTH);
    eWr = (mHead < mCommit) && mAK[mHead % DEPTH] && mDK[mHead % DEPTH];
    chk(memReq, "memWrValid", memWrValid, eWr);
    if (eWr) begin
      chk(memReq, "memWrAddr", memWrAddr, mAddr[mHead % DEPTH]);
      chk(memReq, "memWrData", memWrData, mData[mHead % DEPTH]);
    end
    if (ldValid) begin
      stall = 0; hit = 0; hs = 0;
      hi = (ldPosInt < mTail) ? ldPosInt : mTail;
      for (int p = mHead; p < hi; p++) begin
        if (!mAK[p % DEPTH]) stall = 1;
        else if (mAddr[p % DEPTH] == int'(ldAddr)) begin hit = 1; hs = p % DEPTH; end
      end
      if (stall) begin eKind = 1; req = "R4"; end
      else if (hit && mDK[hs]) begin eKind = 2; req = "R5"; end
      else if (hit) begin eKind = 3; req = "R6"; end
      else begin eKind = 4; req = "R7"; end
      if (ldReq != "") req = ldReq;
      chk(req, "ldKind", ldKind, eKind);
      if (eKind == 2) chk(req, "ldData", ldData, mData[hs]);
      if (eKind == 3) chk(req, "ldTag", ldTag, mTagV[hs]);
    end else begin
      chk("R7", "ldKind idle", ldKind, 0);
    end
    // model update, same order as the requirements state
    if (flushValid) mTail = flushPosInt;
    if (allocValid && eReady) begin
      mAK[mTail % DEPTH] = 0; mDK[mTail % DEPTH] = 0;
      mTagV[mTail % DEPTH] = int'(allocTag); mTail++;
    end
    if (addrValid) begin mAddr[addrSlot] = int'(addrValue); mAK[addrSlot] = 1; end
    if (dataValid) begin mData[dataSlot] = int'(dataValue); mDK[dataSlot] = 1; end
    if (commitValid) mCommit++;
    if (eWr && memWrReady) mHead++;
    @(posedge clk);
    @(negedge clk);
    allocValid = 0; addrValid = 0; dataValid = 0; ldValid = 0;
    commitValid = 0; flushValid = 0;
  endtask

  task automatic doAlloc(int tag);
    allocValid = 1; allocTag = TAG_W'(tag);
  endtask
  task automatic doAddr(int slot, int a);
    addrValid = 1; addrSlot = IDX_W'(slot); addrValue = ADDR_W'(a);
  endtask
  task automatic doData(int slot, int d);
    dataValid = 1; dataSlot = IDX_W'(slot); dataValue = DATA_W'(d);
  endtask
  task automatic doLoad(int pos, int a);
    ldValid = 1; ldPosInt = pos; ldPos = PTR_W'(pos % PMOD); ldAddr = ADDR_W'(a);
  endtask
  task automatic doFlush(int pos);
    flushValid = 1; flushPosInt = pos; flushPos = PTR_W'(pos % PMOD);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mAddr[i] = 0; mData[i] = 0; mTagV[i] = 0; mAK[i] = 0; mDK[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "allocReady", allocReady, 1);
    chk("R1", "memWrValid", memWrValid, 0);
    chk("R1", "tailPos", tailPos, 0);

    // Two stores, addresses unknown: load stalls (R4)
    doAlloc(1); cyc();
    doAlloc(2); cyc();
    doLoad(2, 'h10); cyc();
    doAddr(0, 'h10); doLoad(2, 'h10); cyc();       // R4: slot 1 still unknown
    doAddr(1, 'h20); cyc();
    doLoad(2, 'h10); cyc();                        // R6: match, no data -> tag 1
    ldReq = "R3"; doData(0, 'hAAAA); cyc();
    doLoad(2, 'h10); cyc();                        // R3/R5: forward after separate fills
    ldReq = "";
    doLoad(2, 'h30); cyc();                        // R7: no match
    ldReq = "R8";
    doLoad(1, 'h20); cyc();                        // R8: matching store is younger
    doLoad(0, 'h10); cyc();                        // R8: no older stores
    ldReq = "";

    // Youngest of several matches wins (R5)
    doAlloc(3); cyc();
    doAddr(2, 'h10); doData(2, 'hBBBB); cyc();
    doLoad(3, 'h10); cyc();
    doLoad(2, 'h10); cyc();

    // Release and back-pressure (R9, R10)
    memReq = "R10"; memWrReady = 0;
    commitValid = 1; cyc();
    repeat (3) cyc();
    memWrReady = 1; doLoad(3, 'h10); cyc();
    memReq = "R9";

    // Fill to full, extra allocation dropped (R2)
    doAlloc(4); cyc();
    doAlloc(5); cyc();
    doAlloc(6); cyc();
    doAlloc(7); cyc();

    // Release a store lacking data: no write until data arrives (R9)
    memWrReady = 0; commitValid = 1; cyc();
    cyc();
    doData(1, 'h1234); cyc();
    cyc();

    // Flush younger uncommitted stores, released one keeps draining (R11)
    memReq = "R11";
    doFlush(3); cyc();
    doLoad(3, 'h10); cyc();
    memWrReady = 1; cyc();
    memReq = "R9";
    commitValid = 1; cyc();
    cyc();

    // Random phase against the model
    for (int n = 0; n < 2000; n++) begin
      int live;
      live = mTail - mCommit;
      memWrReady = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 19) == 0 && mTail > mCommit) begin
        doFlush($urandom_range(mCommit, mTail));
      end else begin
        if ($urandom_range(0, 1) == 1) doAlloc($urandom_range(0, 15));
        if (mTail > mCommit && mAK[mCommit % DEPTH] && mDK[mCommit % DEPTH]
            && $urandom_range(0, 2) == 0) commitValid = 1;
      end
      if (live > 0 && $urandom_range(0, 1) == 1)
        doAddr($urandom_range(mCommit, mTail - 1) % DEPTH, $urandom_range(0, 3));
      if (live > 0 && $urandom_range(0, 1) == 1)
        doData($urandom_range(mCommit, mTail - 1) % DEPTH, $urandom_range(0, 65535));
      if ($urandom_range(0, 1) == 1) doLoad($urandom_range(mHead, mTail), $urandom_range(0, 3));
      cyc();
    end
    finish();
  end

endmodule